// File: doc/BRIEF.md
# Packet Checksum Sync-Byte Replacer

This block sits at the transmit end of a framing stage for streams of fixed-length transport packets. Each packet opens with a constant marker byte. The block drops that marker and puts an 8-bit parity checksum in its slot. The checksum covers the payload bytes that came before the slot, so every checksum protects the packet that precedes it. At the receiver, a sliding syndrome over a correct packet gives a fixed value, which serves for both packet delineation and error detection. Payload bytes pass through unchanged, so the code is systematic.

The checksum comes from a bit-serial division register whose feedback polynomial is 1+X+X^5+X^6+X^8. The register takes the payload MSB first. Eight more shifts with the input held at zero drain out eight syndrome bits. An FIR filter with the same polynomial taps shapes those bits, and a fixed offset is added. The input numerator's delayed term (X^1497 times a short polynomial) lies past the end of one span, so it never touches a checksum and is not built. A bypass input makes the block a plain one-stage pipeline for streams that carry no packet marker.

Bytes enter with a start-of-packet strobe on a valid/ready handshake and leave one cycle later through a one-entry output register. The output carries the same strobe.

Top module: `pkt_csum_sync_replacer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Outside bypass, a byte accepted with in_sop=0 appears unchanged on out_data, with out_valid=1, in the cycle after it is accepted.
- R3: The division state is 8 bits and is cleared to zero. For each bit d, taken MSB first: fb = state[7] XOR d, then state = (state << 1) XOR (fb ? 0x63 : 0). Bit i of 0x63 is the X^i coefficient of the polynomial below X^8.
- R4: At a start slot, the syndrome bits y0..y7 are the fb values of eight further shifts with d=0. The checksum bit at position 7-k is y[k] XOR y[k-1] XOR y[k-5] XOR y[k-6], where missing terms count as zero. That byte is XORed with 0x67 and sent in place of the start byte.
- R5: The span a checksum covers is every payload byte accepted since the previous accepted start byte, whatever its length. The state restarts at zero after each start byte, so an empty span gives 0x67.
- R6: The first start byte after reset, and the first after leaving bypass, has no span behind it and passes unchanged. Substitution begins with the next start byte.
- R7: While bypass=1, every byte passes unchanged, start bytes included, and the division state is held at zero.
- R8: in_ready = !out_valid || out_ready. While out_valid=1 and out_ready=0, out_data and out_sop hold their values.
- R9: out_sop equals the in_sop of the byte being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass | input | 1 | Pass all bytes unchanged; division state held clear |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Marks the byte in the start (marker) slot |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take a byte this cycle |
| out_data | output | 8 | Output byte: payload copy or checksum |
| out_sop | output | 1 | Start strobe for the output byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink takes the output byte |

## Verification
The division state cannot be seen directly. A wrong state stays hidden until the next start byte, where it shows up as a wrong checksum byte one cycle after that start byte is accepted. So one corrupted payload bit can go unnoticed for up to a full packet. A bad "primed" flag shows sooner: the first start byte after reset or after bypass is either replaced when it should pass, or passed when it should be replaced. The bench's checksum model uses long division over the zero-extended bit string, not a register copy. Empty spans, short spans, all-ones payloads and backpressure are all driven.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int SYM_W = 8;
  typedef logic [SYM_W-1:0] sym_t;

  // One division shift, MSB-first input.
  function automatic sym_t div_step(sym_t st, logic din, sym_t taps);
    logic fb;
    fb = st[SYM_W-1] ^ din;
    return {st[SYM_W-2:0], 1'b0} ^ (fb ? taps : '0);
  endfunction

  function automatic sym_t div_byte(sym_t st, sym_t b, sym_t taps);
    sym_t s;
    s = st;
    for (int i = SYM_W - 1; i >= 0; i--) s = div_step(s, b[i], taps);
    return s;
  endfunction

  // Zero-input drain: y[k] is the k-th emitted feedback bit.
  function automatic sym_t drain_syndrome(sym_t st, sym_t taps);
    sym_t s;
    sym_t y;
    s = st;
    y = '0;
    for (int k = 0; k < SYM_W; k++) begin
      y[k] = s[SYM_W-1];
      s = div_step(s, 1'b0, taps);
    end
    return y;
  endfunction

  // FIR with the generator taps, zero history; k-th output lands MSB-first.
  function automatic sym_t fir_pack(sym_t y, sym_t taps);
    sym_t o;
    logic acc;
    o = '0;
    for (int k = 0; k < SYM_W; k++) begin
      acc = 1'b0;
      for (int j = 0; j < SYM_W; j++) begin
        if (j <= k && taps[j]) acc = acc ^ y[k-j];
      end
      o[SYM_W-1-k] = acc;
    end
    return o;
  endfunction

  function automatic sym_t finish_csum(sym_t st, sym_t taps, sym_t offset);
    return fir_pack(drain_syndrome(st, taps), taps) ^ offset;
  endfunction
endpackage

// File: rtl/pcs_syndrome_acc.sv
module pcs_syndrome_acc
  import pcs_pkg::*;
#(
  parameter sym_t TAPS = 8'h63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_clear,
  input  logic take,
  input  logic take_sop,
  input  sym_t take_data,
  output sym_t state_o,
  output logic primed_o
);
  sym_t state_q;
  logic primed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= '0;
      primed_q <= 1'b0;
    end else if (hold_clear) begin
      state_q  <= '0;
      primed_q <= 1'b0;
    end else if (take && take_sop) begin
      state_q  <= '0;
      primed_q <= 1'b1;
    end else if (take) begin
      state_q  <= div_byte(state_q, take_data, TAPS);
    end
  end

  assign state_o  = state_q;
  assign primed_o = primed_q;
endmodule

// File: rtl/pcs_csum_final.sv
module pcs_csum_final
  import pcs_pkg::*;
#(
  parameter sym_t TAPS   = 8'h63,
  parameter sym_t OFFSET = 8'h67
) (
  input  sym_t state_i,
  output sym_t csum_o
);
  assign csum_o = finish_csum(state_i, TAPS, OFFSET);
endmodule

// File: rtl/pcs_out_stage.sv
module pcs_out_stage
  import pcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  sym_t ld_data,
  input  logic ld_sop,
  input  logic out_ready,
  output logic space,
  output logic out_valid,
  output sym_t out_data,
  output logic out_sop
);
  logic vld_q;
  sym_t dat_q;
  logic sop_q;

  assign space = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      sop_q <= 1'b0;
    end else if (load) begin
      vld_q <= 1'b1;
      dat_q <= ld_data;
      sop_q <= ld_sop;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_sop   = sop_q;
endmodule

// File: rtl/pkt_csum_sync_replacer.sv
module pkt_csum_sync_replacer
  import pcs_pkg::*;
#(
  parameter logic [pcs_pkg::SYM_W-1:0] GEN_TAPS    = 8'h63,
  parameter logic [pcs_pkg::SYM_W-1:0] CSUM_OFFSET = 8'h67
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bypass,
  input  logic [pcs_pkg::SYM_W-1:0] in_data,
  input  logic                      in_sop,
  input  logic                      in_valid,
  output logic                      in_ready,
  output logic [pcs_pkg::SYM_W-1:0] out_data,
  output logic                      out_sop,
  output logic                      out_valid,
  input  logic                      out_ready
);
  // Named internal events, brought out for the checker.
  logic take;
  logic slot_take;
  logic replace_fire;
  logic primed;
  sym_t acc_state;
  sym_t csum;
  sym_t pick_data;
  logic space;

  assign take         = in_valid && space;
  assign slot_take    = take && in_sop;
  assign replace_fire = slot_take && primed && !bypass;
  assign in_ready     = space;
  assign pick_data    = replace_fire ? csum : in_data;

  pcs_syndrome_acc #(.TAPS(GEN_TAPS)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_clear(bypass),
    .take      (take),
    .take_sop  (in_sop),
    .take_data (in_data),
    .state_o   (acc_state),
    .primed_o  (primed)
  );

  pcs_csum_final #(.TAPS(GEN_TAPS), .OFFSET(CSUM_OFFSET)) u_fin (
    .state_i(acc_state),
    .csum_o (csum)
  );

  pcs_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .ld_data  (pick_data),
    .ld_sop   (in_sop),
    .out_ready(out_ready),
    .space    (space),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_sop  (out_sop)
  );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bypass,
  input logic [7:0] in_data,
  input logic       in_sop,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] out_data,
  input logic       out_sop,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] acc_state,
  input logic       primed,
  input logic       slot_take
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop)); // R8
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8
  AST_PAYLOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_sop |=> out_valid && out_data == $past(in_data)); // R2
  AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && bypass |=> out_data == $past(in_data)); // R7
  AST_BYPASS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> acc_state == 8'h00 && !primed); // R7
  AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_sop && !primed |=> out_data == $past(in_data)); // R6
  AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    slot_take && !bypass |=> acc_state == 8'h00 && primed); // R5
  AST_SOP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_sop == $past(in_sop)); // R9
endmodule

bind pkt_csum_sync_replacer pcs_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bypass   (bypass),
  .in_data  (in_data),
  .in_sop   (in_sop),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_data (out_data),
  .out_sop  (out_sop),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .acc_state(acc_state),
  .primed   (primed),
  .slot_take(slot_take)
);

// File: tb/tb_pkt_csum_sync_replacer.sv
`timescale 1ns/1ps
module tb_pkt_csum_sync_replacer;
  localparam int CLK_NS = 8;

  logic       clk = 1'b0;
  logic       rst_n, bypass, in_sop, in_valid, out_ready;
  logic [7:0] in_data;
  logic       in_ready, out_sop, out_valid;
  logic [7:0] out_data;

  int n_run = 0;
  int n_fail = 0;
  logic [8:0] stim_q[$];
  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] pay_q[$];
  logic       primed_m = 1'b0;
  logic       stalled_prev = 1'b0;
  logic [8:0] held = '0;
  bit         done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  pkt_csum_sync_replacer dut (
    .clk(clk), .rst_n(rst_n), .bypass(bypass),
    .in_data(in_data), .in_sop(in_sop), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_sop(out_sop), .out_valid(out_valid), .out_ready(out_ready)
  );

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Long division of (span bits, then 16 zeros) by 1+X+X^5+X^6+X^8;
  // the last 8 quotient bits are the syndrome, then FIR and offset.
  function automatic logic [7:0] ref_csum(logic [7:0] b[$]);
    logic [8:0] r;
    logic [7:0] y, c;
    logic       bin, o;
    int         nbits, total;
    r = '0; y = '0; c = '0;
    nbits = b.size() * 8;
    total = nbits + 16;
    for (int i = 0; i < total; i++) begin
      bin = (i < nbits) ? b[i/8][7-(i%8)] : 1'b0;
      r = {r[7:0], bin};
      if (i >= total - 8) y[i-(total-8)] = r[8];
      if (r[8]) r = r ^ 9'h163;
    end
    for (int k = 0; k < 8; k++) begin
      o = y[k];
      if (k >= 1) o = o ^ y[k-1];
      if (k >= 5) o = o ^ y[k-5];
      if (k >= 6) o = o ^ y[k-6];
      c[7-k] = o;
    end
    return c ^ 8'h67;
  endfunction

  task automatic model_take(logic [8:0] item);
    if (bypass) begin
      exp_q.push_back(item); tag_q.push_back("R7 bypass copy");
    end else if (item[8]) begin
      if (primed_m) begin
        exp_q.push_back({1'b1, ref_csum(pay_q)});
        if (pay_q.size() == 0) tag_q.push_back("R5 empty span checksum");
        else if (pay_q.size() != 187) tag_q.push_back("R5 short span checksum");
        else tag_q.push_back("R3/R4 packet checksum");
      end else begin
        exp_q.push_back(item); tag_q.push_back("R6 first start byte unchanged");
      end
      primed_m = 1'b1;
      pay_q.delete();
    end else begin
      exp_q.push_back(item); tag_q.push_back("R2 payload copy");
      pay_q.push_back(item[7:0]);
    end
  endtask

  task automatic add_packet(int n, int kind);
    logic [7:0] v;
    stim_q.push_back({1'b1, 8'h47});
    for (int i = 0; i < n; i++) begin
      v = (kind == 1) ? 8'hFF : (kind == 2) ? 8'h00 : 8'($urandom);
      stim_q.push_back({1'b0, v});
    end
  endtask

  task automatic drain();
    int guard = 0;
    logic [8:0] e;
    string t;
    while ((stim_q.size() > 0 || exp_q.size() > 0) && guard < 40000) begin
      guard++;
      @(negedge clk);
      if (stim_q.size() > 0 && ($urandom % 5) != 0) begin
        in_valid = 1'b1; in_sop = stim_q[0][8]; in_data = stim_q[0][7:0];
      end else begin
        in_valid = 1'b0;
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      if (stalled_prev) chk("R8 output held while stalled", {out_sop, out_data}, held);
      if (out_valid && !out_ready) chk("R8 in_ready low while stalled", {8'h00, in_ready}, 9'h000);
      stalled_prev = out_valid && !out_ready;
      held = {out_sop, out_data};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk("R9 unexpected output byte", {out_sop, out_data}, 9'h1FF ^ {out_sop, out_data});
        end else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(t, {out_sop, out_data}, e);
        end
      end
      if (in_valid && in_ready) model_take(stim_q.pop_front());
    end
    if (guard >= 40000) chk("R8 stream stalled", 9'h000, 9'h001);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1; stalled_prev = 1'b0;
  endtask

  task automatic set_bypass(logic v);
    @(negedge clk);
    bypass = v;
    primed_m = 1'b0;
    pay_q.delete();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bypass = 1'b0; in_sop = 1'b0; in_valid = 1'b0;
    in_data = 8'h00; out_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 out_valid after reset", {8'h00, out_valid}, 9'h000);
    chk("R1 in_ready after reset", {8'h00, in_ready}, 9'h001);

    // Normal framing: first start byte passes, then full packets.
    add_packet(187, 0);
    for (int p = 0; p < 5; p++) add_packet(187, 0);
    add_packet(187, 1);
    add_packet(187, 2);
    add_packet(0, 0);      // empty span follows
    add_packet(3, 0);      // short span
    stim_q.push_back({1'b1, 8'h47});
    drain();

    // Bypass: start bytes pass untouched.
    set_bypass(1'b1);
    add_packet(187, 0);
    add_packet(20, 1);
    stim_q.push_back({1'b1, 8'h47});
    drain();

    // Leaving bypass: first start byte passes again.
    set_bypass(1'b0);
    add_packet(187, 0);
    add_packet(187, 0);
    stim_q.push_back({1'b1, 8'h47});
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule